// File: doc/BRIEF.md
# Software Interrupt Pending Register with Level Masking

This block holds a 17-bit word of pending software interrupts and a 4-bit interrupt level. Each bit that is pending and allowed by the current level drives its own request output. Software changes the pending word through a small register bus that offers three kinds of write: a plain overwrite, an OR-in alias, and a clear-by-mask alias. A fourth address holds the level.

The masking is different for the two edge bits. Bit 0 and bit 16 pass only while the level is below a fixed threshold of 14. Bits 1 to 15 each pass only when the bit index is strictly greater than the level. A one-cycle timer-match pulse from outside sets bit 16 directly, so a counter compare can raise a software interrupt without a bus write.

Requests are combinational from the two registers, so they follow a write on the same clock edge that stores it. Taking the trap, vectoring to a handler and acknowledging the request are left to the consumer of the request lines.

Top module: `softint_irq_ctrl`

## Requirements
- R1: After reset the pending word is 0, the level is 0 and every request output is low.
- R2: A write to address 0 replaces the pending word with the write data.
- R3: A write to address 1 ORs the write data into the pending word.
- R4: A write to address 2 clears every pending bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: A write to address 3 loads the level from write-data bits 3:0, and the upper write-data bits have no effect. A read of address 3 returns the level in bits 3:0, with zeros above.
- R6: For each bit n from 1 to 15, request n is high exactly when pending bit n is 1 and n is strictly greater than the level.
- R7: Requests 0 and 16 are high exactly when their pending bit is 1 and the level is below 14.
- R8: A timer-match pulse sets pending bit 16 and leaves the other bits unchanged. When a bus write happens in the same cycle, the write is applied first and the pulse then forces bit 16 to 1.
- R9: Reads of addresses 0, 1 and 2 all return the current pending word.
- R10: The request outputs reflect a new level or a new pending word right after the clock edge that stores it, with no extra cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register select: 0 pending, 1 set alias, 2 clear alias, 3 level |
| wdata_i | input | 17 | Write data |
| rdata_o | output | 17 | Read data for addr_i |
| timer_hit_i | input | 1 | Timer-match pulse that sets pending bit 16 |
| irq_o | output | 17 | Masked request lines, one per pending bit |

## Verification
The assertions assume that reset is applied before the first write and that the write data and the timer pulse are known (never X) at every clock edge while the strobe is high. The clear-alias assertion also assumes the timer pulse is low in that cycle, because the pulse is allowed to override bit 16. The bench drives every input from a known value on the falling edge and releases the strobe and the pulse one cycle later. It sweeps all 16 levels against an all-ones pending word and against a single walking bit. This covers both sides of the fixed threshold and the index comparison.

// File: rtl/softint_pkg.sv
package softint_pkg;
  typedef enum logic [1:0] {
    ADDR_PEND = 2'd0,
    ADDR_SET  = 2'd1,
    ADDR_CLR  = 2'd2,
    ADDR_LVL  = 2'd3
  } sw_addr_e;
endpackage

// File: rtl/softint_pend_reg.sv
module softint_pend_reg
  import softint_pkg::*;
#(
  parameter int NUM_BITS = 17,
  parameter int TMR_BIT  = NUM_BITS - 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [1:0]          addr_i,
  input  logic [NUM_BITS-1:0] wdata_i,
  input  logic                timer_hit_i,
  output logic [NUM_BITS-1:0] pend_o
);
  logic [NUM_BITS-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (wr_en_i) begin
      unique case (sw_addr_e'(addr_i))
        ADDR_PEND: pend_d = wdata_i;
        ADDR_SET:  pend_d = pend_q | wdata_i;
        ADDR_CLR:  pend_d = pend_q & ~wdata_i;
        default:   pend_d = pend_q;
      endcase
    end
    // timer match is applied after the bus write
    if (timer_hit_i) pend_d[TMR_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  assert_set_or_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_SET) |=>
      ((pend_q & $past(wdata_i)) == $past(wdata_i)) &&
      ((pend_q & $past(pend_q)) == $past(pend_q)));

  assert_clr_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_CLR && !timer_hit_i) |=>
      ((pend_q & $past(wdata_i)) == '0));

  assert_timer_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_hit_i |=> pend_q[TMR_BIT]);

  assert_timer_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timer_hit_i && !wr_en_i) |=>
      ((pend_q ^ $past(pend_q)) & ~(NUM_BITS'(1) << TMR_BIT)) == '0);
endmodule

// File: rtl/softint_level_reg.sv
module softint_level_reg
  import softint_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [LVL_W-1:0] wdata_i,
  output logic [LVL_W-1:0] level_o
);
  logic [LVL_W-1:0] level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             level_q <= '0;
    else if (wr_en_i && addr_i == ADDR_LVL)  level_q <= wdata_i;
  end

  assign level_o = level_q;

  assert_level_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_LVL) |=> $stable(level_q));
endmodule

// File: rtl/softint_req_mask.sv
module softint_req_mask #(
  parameter int NUM_BITS = 17,
  parameter int LVL_W    = 4,
  parameter int THRESH   = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_BITS-1:0] pend_i,
  input  logic [LVL_W-1:0]    level_i,
  output logic [NUM_BITS-1:0] irq_o
);
  localparam int CMP_W = $clog2(NUM_BITS) + 1;
  localparam int TOP   = NUM_BITS - 1;

  logic [CMP_W-1:0] lvl_ext;
  assign lvl_ext = CMP_W'(level_i);

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
    if (i == 0 || i == TOP) begin : g_fixed
      assign irq_o[i] = pend_i[i] && (lvl_ext < CMP_W'(THRESH));
    end else begin : g_idx
      assign irq_o[i] = pend_i[i] && (CMP_W'(i) > lvl_ext);
      assert_idx_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o[i] |-> (level_i < LVL_W'(i)));
    end
  end

  assert_req_subset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~pend_i) == '0);

  assert_edge_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CMP_W'(level_i) >= CMP_W'(THRESH)) |-> !irq_o[0] && !irq_o[TOP]);
endmodule

// File: rtl/softint_irq_ctrl.sv
module softint_irq_ctrl
  import softint_pkg::*;
#(
  parameter int NUM_BITS = 17,
  parameter int LVL_W    = 4,
  parameter int THRESH   = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [1:0]          addr_i,
  input  logic [NUM_BITS-1:0] wdata_i,
  output logic [NUM_BITS-1:0] rdata_o,
  input  logic                timer_hit_i,
  output logic [NUM_BITS-1:0] irq_o
);
  logic [NUM_BITS-1:0] pend;
  logic [LVL_W-1:0]    level;

  softint_pend_reg #(.NUM_BITS(NUM_BITS)) u_pend (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .timer_hit_i, .pend_o(pend)
  );

  softint_level_reg #(.LVL_W(LVL_W)) u_level (
    .clk_i, .rst_ni, .wr_en_i, .addr_i,
    .wdata_i(wdata_i[LVL_W-1:0]), .level_o(level)
  );

  softint_req_mask #(.NUM_BITS(NUM_BITS), .LVL_W(LVL_W), .THRESH(THRESH)) u_mask (
    .clk_i, .rst_ni, .pend_i(pend), .level_i(level), .irq_o
  );

  assign rdata_o = (addr_i == ADDR_LVL) ? NUM_BITS'(level) : pend;

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (irq_o == '0) || !rst_ni);
endmodule

// File: tb/softint_irq_ctrl_tb.sv
`timescale 1ns/1ps
module softint_irq_ctrl_tb;
  logic        clk = 0, rst_ni = 0, wr_en = 0, tmr = 0;
  logic [1:0]  addr = 0;
  logic [16:0] wdata = 0, rdata, irq;
  logic [16:0] m_pend = 0;
  logic [3:0]  m_lvl = 0;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  softint_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .timer_hit_i(tmr), .irq_o(irq)
  );

  function automatic logic [16:0] exp_irq(logic [16:0] p, logic [3:0] l);
    logic [16:0] r = '0;
    for (int b = 0; b < 17; b++)
      if (b == 0 || b == 16) r[b] = p[b] && (l < 14);
      else                   r[b] = p[b] && (b > int'(l));
    return r;
  endfunction

  task automatic chk(string req, logic [16:0] act, logic [16:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle; the model mirrors the requirements
  task automatic op(logic w, logic [1:0] a, logic [16:0] d, logic t);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; tmr = t;
    @(negedge clk);
    wr_en = 0; tmr = 0;
    if (w) case (a)
      2'd0: m_pend = d;
      2'd1: m_pend = m_pend | d;
      2'd2: m_pend = m_pend & ~d;
      default: m_lvl = d[3:0];
    endcase
    if (t) m_pend[16] = 1'b1;
  endtask

  task automatic rd(logic [1:0] a, string req, logic [16:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 irq", irq, '0);
    rd(2'd0, "R1 pending", '0);
    rd(2'd3, "R1 level", '0);

    for (int l = 0; l < 16; l++) begin
      op(1, 2'd3, 17'h1fff0 | 17'(l), 0);   // upper bits must be ignored
      rd(2'd3, "R5 level read", 17'(l));
      op(1, 2'd0, 17'h1ffff, 0);
      chk("R6 R7 R10 all-ones", irq, exp_irq(m_pend, m_lvl));
      for (int b = 0; b < 17; b++) begin
        op(1, 2'd0, 17'(1) << b, 0);
        chk("R2 R6 R7 walking", irq, exp_irq(m_pend, m_lvl));
      end
    end

    op(1, 2'd3, 17'd0, 0);
    op(1, 2'd0, 17'h00a05, 0);
    rd(2'd0, "R2 direct", 17'h00a05);
    op(1, 2'd1, 17'h10300, 0);
    rd(2'd1, "R3 R9 set alias", 17'h10b05);
    rd(2'd2, "R9 clear alias read", 17'h10b05);
    op(1, 2'd2, 17'h00a01, 0);
    rd(2'd0, "R4 clear alias", 17'h10104);
    chk("R6 R7 after clear", irq, exp_irq(17'h10104, 4'd0));

    op(1, 2'd3, 17'd13, 0);
    chk("R7 R10 level 13", irq, exp_irq(m_pend, 4'd13));
    op(1, 2'd3, 17'd14, 0);
    chk("R7 R10 level 14", irq, exp_irq(m_pend, 4'd14));
    op(1, 2'd3, 17'd0, 0);

    op(1, 2'd0, 17'h00003, 0);
    op(0, 2'd0, 17'h0, 1);
    rd(2'd0, "R8 timer alone", 17'h10003);
    op(1, 2'd2, 17'h10001, 1);
    rd(2'd0, "R8 timer vs clear", 17'h10002);
    op(1, 2'd0, 17'h00000, 1);
    rd(2'd0, "R8 timer vs direct", 17'h10000);
    op(1, 2'd1, 17'h00010, 1);
    rd(2'd0, "R8 timer with set", 17'h10010);
    chk("R8 irq", irq, exp_irq(m_pend, m_lvl));

    @(negedge clk);
    rst_ni = 0;
    @(negedge clk);
    chk("R1 irq in reset", irq, '0);
    rd(2'd0, "R1 pending in reset", '0);
    rst_ni = 1;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule